// File: doc/BRIEF.md
# Nearest-Level Arm Count Modulator

This block turns a signed reference voltage sample into the number of submodules that must be inserted in each arm of one modular multilevel converter leg. On each sample strobe it rounds the reference to the nearest whole multiple of the nominal submodule capacitor voltage. The rounded level is then offset by half the arm size, which gives the lower-arm count. The upper-arm count is the complement of that count. A zero reference therefore inserts half of each arm.

The reference and the capacitor voltage use the same signed fixed-point scaling, with `FRAC` fractional bits. The arm size `N_ARM` must be even, so that the zero level can be reached and the leg has `N_ARM + 1` levels. With the defaults the capacitor voltage is 10 V and there are 20 submodules per arm. Both counts are registered. They come with a one-cycle change flag that tells the downstream balancing stage a new insertion pattern is due.

Top module: `nlc_arm_counter`

## Requirements
- R1: During and directly after reset, `n_low` and `n_up` both equal `N_ARM/2` and `chg` is 0.
- R2: For a strobed sample `v_ref`, `n_low` becomes round(`v_ref` / `VC_NOM`) + `N_ARM/2`. Both values are read as signed two's-complement numbers with the same scaling.
- R3: A quotient that lies exactly halfway between two integers rounds away from zero, for positive and negative references alike. With the defaults, a magnitude of 80 rounds to level 1 and −80 rounds to level −1.
- R4: `n_low` is clamped to the range 0 to `N_ARM`, so a reference beyond the converter's range gives a count of 0 or `N_ARM`.
- R5: `n_up` always equals `N_ARM - n_low`.
- R6: Counts change only on the rising edge that follows a cycle with `smp_vld` high. In any other cycle they hold their value, whatever `v_ref` does.
- R7: `chg` is high for exactly the one cycle after a strobe whose sample changes `n_low`. A strobe that leaves the counts unchanged leaves `chg` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe for `v_ref` |
| v_ref | input | REF_W | Signed fixed-point reference voltage |
| n_low | output | CW | Submodules to insert in the lower arm |
| n_up | output | CW | Submodules to insert in the upper arm |
| chg | output | 1 | One-cycle pulse when the counts changed |

## Verification
A new sample can be taken in the same cycle that `chg` reports the previous one. The bench provokes this by strobing every cycle across the whole input range. The sweep crosses each level boundary and the saturation points. The bench judges each cycle's counts and flag against the model's value for the sample strobed one cycle earlier. A repeated sample, strobed back to back, must give a clear `chg` in the cycle after a pulse. A hold phase changes `v_ref` without a strobe and checks that neither the counts nor the flag move.

// File: rtl/nlc_arm_counter.sv
module nlc_arm_counter #(
  parameter int REF_W  = 16,
  parameter int FRAC   = 4,
  parameter int VC_NOM = 10 << FRAC,
  parameter int N_ARM  = 20,
  localparam int CW    = $clog2(N_ARM + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [REF_W-1:0] v_ref,
  output logic [CW-1:0]           n_low,
  output logic [CW-1:0]           n_up,
  output logic                    chg
);
  localparam int AW   = REF_W + 2;
  localparam int HALF = N_ARM / 2;

  logic signed [AW-1:0] ref_x;
  logic                 neg;
  logic [AW-1:0]        mag;
  logic [AW:0]          num, q;
  logic signed [AW+1:0] lvl, low_raw, up_raw;
  logic [CW-1:0]        low_nx, up_nx;

  function automatic logic [CW-1:0] clamp(input logic signed [AW+1:0] v);
    if (v < 0) return '0;
    if (v > (AW+2)'(N_ARM)) return CW'(N_ARM);
    return CW'(v);
  endfunction

  assign ref_x   = {{2{v_ref[REF_W-1]}}, v_ref};
  assign neg     = v_ref[REF_W-1];
  assign mag     = neg ? AW'(-ref_x) : AW'(ref_x);
  assign num     = {mag, 1'b0} + (AW+1)'(VC_NOM);
  assign q       = num / (AW+1)'(2 * VC_NOM);
  assign lvl     = neg ? -$signed({1'b0, q}) : $signed({1'b0, q});
  assign low_raw = lvl + (AW+2)'(HALF);
  assign up_raw  = (AW+2)'(HALF) - lvl;
  assign low_nx  = clamp(low_raw);
  assign up_nx   = clamp(up_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_low <= CW'(HALF);
      n_up  <= CW'(HALF);
      chg   <= 1'b0;
    end else begin
      chg <= smp_vld && (low_nx != n_low);
      if (smp_vld) begin
        n_low <= low_nx;
        n_up  <= up_nx;
      end
    end
  end

  // R5
  arm_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW+1)'(n_low) + (CW+1)'(n_up) == (CW+1)'(N_ARM));
  // R4
  low_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_low <= CW'(N_ARM));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(n_low) && $stable(n_up));
  // R7
  chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> $past(smp_vld));
  // R7
  chg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld) |-> (chg == (n_low != $past(n_low))));
endmodule

// File: tb/sim_nlc_arm_counter.sv
module sim_nlc_arm_counter;
  localparam int REF_W = 16, FRAC = 4, VC = 10 << FRAC, N = 20;
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, smp_vld = 0;
  logic signed [REF_W-1:0] v_ref = '0;
  logic [CW-1:0] n_low, n_up;
  logic chg;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  nlc_arm_counter #(.REF_W(REF_W), .FRAC(FRAC), .VC_NOM(VC), .N_ARM(N)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_ref(v_ref),
    .n_low(n_low), .n_up(n_up), .chg(chg));

  function automatic int exp_low(int r);
    int a, q, l;
    a = (r < 0) ? -r : r;
    q = (2 * a + VC) / (2 * VC);
    l = ((r < 0) ? -q : q) + N / 2;
    if (l < 0) l = 0;
    if (l > N) l = N;
    return l;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (v_ref=%0d)", req, act, exp, v_ref);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int prev, cur, pr;
    string tag;
    repeat (3) @(negedge clk);
    chk("R1 low", n_low, N / 2);
    chk("R1 up", n_up, N / 2);
    chk("R1 chg", chg, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 low after release", n_low, N / 2);
    chk("R1 chg after release", chg, 0);

    // back-to-back strobes over the full input range
    prev = N / 2;
    smp_vld = 1;
    v_ref = -32768;
    pr = -32768;
    for (int r = -32767; r <= 32768; r++) begin
      @(negedge clk);
      cur = exp_low(pr);
      if (cur == 0 || cur == N) tag = "R4";
      else if (((pr < 0 ? -pr : pr) % VC) == VC / 2) tag = "R3";
      else tag = "R2";
      chk(tag, n_low, cur);
      chk("R5", n_up, N - cur);
      chk("R7", chg, cur != prev);
      prev = cur;
      pr = r;
      if (r <= 32767) v_ref = REF_W'(r);
    end

    // explicit ties, strobed twice each: the repeat must clear chg
    foreach (pr_list[i]) begin
      v_ref = REF_W'(pr_list[i]);
      @(negedge clk);
      chk("R3 tie", n_low, exp_low(pr_list[i]));
      chk("R7 pulse", chg, exp_low(pr_list[i]) != prev);
      prev = exp_low(pr_list[i]);
      @(negedge clk);
      chk("R7 repeat no chg", chg, 0);
    end

    // hold: no strobe, reference moves
    smp_vld = 0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      v_ref = REF_W'(k * 700 - 2800);
      @(negedge clk);
      chk("R6 hold low", n_low, prev);
      chk("R6 hold up", n_up, N - prev);
      chk("R6 no chg", chg, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int pr_list[6] = '{80, -80, 240, -240, 1520, -1520};
endmodule